// File: doc/BRIEF.md
# Integer ALU with Encoded Compare Modes and Registered Flags

This block is the arithmetic unit of a small core whose instructions come in 16-bit and 32-bit forms. Its data path is combinational. It takes two register operands, `opa` and `opb`, and an 8-bit signed immediate. A select chooses whether the immediate, sign-extended, replaces `opa`'s partner `opb` as the second operand. A 4-bit operation code picks one of add, subtract, AND, OR, XOR, logical left shift or logical right shift. The block returns the `W`-bit result.

A separate 4-bit compare-mode field drives the one-bit compare output in parallel with the result. The low two bits of that field pick a base condition: equal, signed greater-or-equal, signed greater-than, or constant true. The top bit inverts the base condition, which yields not-equal, less-than, less-or-equal and constant false.

Two flags are held in flip-flops:
- The truth flag captures the compare output on a clock edge when its write enable is high.
- The overflow flag captures signed overflow of an add or subtract on a clock edge when its own write enable is high.

The no-operation setting is the OR code with both enables low.

Top module: `alu_cmp_unit`

## Requirements
- R1: Operation codes 0011 (ADD) and 0111 (ADDI) give `opa` plus the second operand, and 0001 (SUB) gives `opa` minus it, all modulo 2^W. ADDI always uses the sign-extended immediate as the second operand, whatever `use_imm` is.
- R2: Codes 0010 (AND), 0000 (OR) and 0100 (XOR) give the bitwise function of `opa` and the second operand.
- R3: Code 0101 shifts `opa` left and code 0110 shifts it right, logically (zero fill). The shift amount is the low log2(W) bits of the second operand.
- R4: When `use_imm` is 1, the second operand is `imm` sign-extended to W bits. When it is 0, the second operand is `opb`.
- R5: The low two bits of `cmp_mode` select the base condition: 00 equal, 01 signed greater-or-equal, 10 signed greater-than, 11 constant true. Bit 3 inverts the base condition, so 1000 is not-equal, 1001 less-than, 1010 less-or-equal and 1011 constant false. Bit 2 is ignored.
- R6: The ordering compares treat `opa` and the second operand as two's-complement signed numbers.
- R7: On a rising clock edge with `tflag_we` high, `tflag` takes the value `cmp_out` had before the edge. With `tflag_we` low, `tflag` keeps its value.
- R8: On a rising clock edge with `ovf_we` high and an ADD, ADDI or SUB code applied, `ovf` takes the signed overflow of that operation. In every other case `ovf` keeps its value.
- R9: While `rst_n` is low, `tflag` and `ovf` are 0.
- R10: Codes 1000 (CMP) through 1111 drive `result` to zero. `cmp_out` still follows R5 for these codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| opa | input | W | First operand |
| opb | input | W | Register second operand |
| imm | input | IMM_W | Signed immediate |
| use_imm | input | 1 | Selects the sign-extended immediate as the second operand |
| op | input | 4 | Operation code |
| cmp_mode | input | 4 | Compare-mode field |
| tflag_we | input | 1 | Truth flag write enable |
| ovf_we | input | 1 | Overflow flag write enable |
| result | output | W | Operation result |
| cmp_out | output | 1 | Compare result |
| tflag | output | 1 | Registered truth flag |
| ovf | output | 1 | Registered overflow flag |

## Verification
The bench builds the block with its defaults, W = 32 and IMM_W = 8. With these values every shift amount from 0 to 31 is reachable, and so is every immediate from -128 to 127. Signed boundaries such as the most positive plus one, and the most negative minus one, can be driven directly to exercise the overflow and signed-compare paths. Random operands are drawn with biased sign bits and frequent equal pairs, so that the equality and the ordering modes are both met often.

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit #(
  parameter int W     = 32,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic [3:0]       op,
  input  logic [3:0]       cmp_mode,
  input  logic             tflag_we,
  input  logic             ovf_we,
  output logic [W-1:0]     result,
  output logic             cmp_out,
  output logic             tflag,
  output logic             ovf
);
  localparam int SHW = $clog2(W);

  localparam logic [3:0] OP_OR   = 4'b0000;
  localparam logic [3:0] OP_SUB  = 4'b0001;
  localparam logic [3:0] OP_AND  = 4'b0010;
  localparam logic [3:0] OP_ADD  = 4'b0011;
  localparam logic [3:0] OP_XOR  = 4'b0100;
  localparam logic [3:0] OP_LSH  = 4'b0101;
  localparam logic [3:0] OP_RSH  = 4'b0110;
  localparam logic [3:0] OP_ADDI = 4'b0111;

  logic [W-1:0]   imm_ext, src_b, sum, diff;
  logic [SHW-1:0] shamt;
  logic           is_add, is_sub, eq, gt, base, ovf_next;

  assign imm_ext = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
  assign src_b   = (use_imm || op == OP_ADDI) ? imm_ext : opb;
  assign sum     = opa + src_b;
  assign diff    = opa - src_b;
  assign shamt   = src_b[SHW-1:0];

  assign is_add  = (op == OP_ADD) || (op == OP_ADDI);
  assign is_sub  = (op == OP_SUB);

  always_comb begin
    case (op)
      OP_OR:   result = opa | src_b;
      OP_SUB:  result = diff;
      OP_AND:  result = opa & src_b;
      OP_ADD:  result = sum;
      OP_XOR:  result = opa ^ src_b;
      OP_LSH:  result = opa << shamt;
      OP_RSH:  result = opa >> shamt;
      OP_ADDI: result = sum;
      default: result = '0;
    endcase
  end

  assign eq = (opa == src_b);
  assign gt = $signed(opa) > $signed(src_b);

  always_comb begin
    case (cmp_mode[1:0])
      2'b00:   base = eq;
      2'b01:   base = eq | gt;
      2'b10:   base = gt;
      default: base = 1'b1;
    endcase
  end

  assign cmp_out = base ^ cmp_mode[3];

  always_comb begin
    ovf_next = 1'b0;
    if (is_add)
      ovf_next = (opa[W-1] == src_b[W-1]) && (sum[W-1] != opa[W-1]);
    else if (is_sub)
      ovf_next = (opa[W-1] != src_b[W-1]) && (diff[W-1] != opa[W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tflag <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (tflag_we) tflag <= cmp_out;
      if (ovf_we && (is_add || is_sub)) ovf <= ovf_next;
    end
  end

  // R7
  tflag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tflag_we |=> tflag == $past(cmp_out));

  // R7
  tflag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tflag_we |=> $stable(tflag));

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_we && (is_add || is_sub)) |=> $stable(ovf));

  // R5
  const_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode[1:0] == 2'b11) |-> (cmp_out == !cmp_mode[3]));

  // R5
  eq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode[1:0] == 2'b00) |-> (cmp_out == ((opa == src_b) ^ cmp_mode[3])));

  // R10
  high_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op[3] |-> (result == '0));

  // R9
  reset_flags_chk: assert property (@(posedge clk)
    !rst_n |-> (!tflag && !ovf));
endmodule

// File: tb/sim_alu_cmp_unit.sv
module sim_alu_cmp_unit;
  localparam int W = 32;
  localparam int IMM_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [IMM_W-1:0] imm = '0;
  logic use_imm = 1'b0;
  logic [3:0] op = 4'b0000, cmp_mode = 4'b0000;
  logic tflag_we = 1'b0, ovf_we = 1'b0;
  logic [W-1:0] result;
  logic cmp_out, tflag, ovf;

  int checks = 0, errors = 0;
  logic m_tflag = 1'b0, m_ovf = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  alu_cmp_unit #(.W(W), .IMM_W(IMM_W)) u0 (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .imm(imm), .use_imm(use_imm),
    .op(op), .cmp_mode(cmp_mode), .tflag_we(tflag_we), .ovf_we(ovf_we),
    .result(result), .cmp_out(cmp_out), .tflag(tflag), .ovf(ovf));

  function automatic logic [W-1:0] f_b(logic [3:0] o, logic ui, logic [W-1:0] b, logic [IMM_W-1:0] i);
    logic [W-1:0] ie = {{(W-IMM_W){i[IMM_W-1]}}, i};
    return (ui || o == 4'b0111) ? ie : b;
  endfunction

  function automatic logic [W-1:0] f_res(logic [3:0] o, logic [W-1:0] a, logic [W-1:0] b);
    case (o)
      4'b0000: return a | b;
      4'b0001: return a - b;
      4'b0010: return a & b;
      4'b0011, 4'b0111: return a + b;
      4'b0100: return a ^ b;
      4'b0101: return a << b[4:0];
      4'b0110: return a >> b[4:0];
      default: return '0;
    endcase
  endfunction

  function automatic logic f_cmp(logic [3:0] m, logic [W-1:0] a, logic [W-1:0] b);
    logic r;
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    case (m[1:0])
      2'b00: r = (sa == sb);
      2'b01: r = (sa >= sb);
      2'b10: r = (sa > sb);
      default: r = 1'b1;
    endcase
    return m[3] ? !r : r;
  endfunction

  function automatic logic f_ovf(logic [3:0] o, logic [W-1:0] a, logic [W-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint r;
    if (o == 4'b0011 || o == 4'b0111) r = sa + sb;
    else r = sa - sb;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] o, logic [3:0] m, logic [W-1:0] a, logic [W-1:0] b,
                       logic [IMM_W-1:0] i, logic ui, logic twe, logic owe, string tag);
    logic [W-1:0] be;
    @(negedge clk);
    op = o; cmp_mode = m; opa = a; opb = b; imm = i; use_imm = ui;
    tflag_we = twe; ovf_we = owe;
    be = f_b(o, ui, b, i);
    #2;
    check({tag, " result"}, result, f_res(o, a, be));
    check({tag, " cmp_out R5 R6"}, {31'b0, cmp_out}, {31'b0, f_cmp(m, a, be)});
    if (twe) m_tflag = f_cmp(m, a, be);
    if (owe && (o == 4'b0011 || o == 4'b0111 || o == 4'b0001)) m_ovf = f_ovf(o, a, be);
    @(posedge clk);
    #2;
    check({tag, " tflag R7"}, {31'b0, tflag}, {31'b0, m_tflag});
    check({tag, " ovf R8"}, {31'b0, ovf}, {31'b0, m_ovf});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #25;
    check("R9 tflag in reset", {31'b0, tflag}, 32'd0);
    check("R9 ovf in reset", {31'b0, ovf}, 32'd0);
    rst_n = 1'b1;

    // Directed corners
    apply(4'b0011, 4'b0000, 32'h7FFFFFFF, 32'h1, 8'h0, 1'b0, 1'b1, 1'b1, "R1 add overflow");
    apply(4'b0001, 4'b1001, 32'h80000000, 32'h1, 8'h0, 1'b0, 1'b1, 1'b1, "R1 sub overflow");
    apply(4'b0001, 4'b0000, 32'h5, 32'h5, 8'h0, 1'b0, 1'b1, 1'b1, "R1 sub no overflow");
    apply(4'b0111, 4'b0001, 32'h10, 32'hDEAD, 8'h80, 1'b0, 1'b0, 1'b1, "R1 addi ignores use_imm");
    apply(4'b0010, 4'b0000, 32'hFFFFFFFF, 32'h0, 8'hF0, 1'b1, 1'b0, 1'b0, "R4 R2 and with imm");
    apply(4'b0000, 4'b0011, 32'h0, 32'h0, 8'h00, 1'b0, 1'b1, 1'b0, "R2 nop or");
    apply(4'b0100, 4'b1011, 32'hA5A5A5A5, 32'hFFFF0000, 8'h0, 1'b0, 1'b1, 1'b0, "R2 xor const false");
    apply(4'b0101, 4'b0010, 32'h1, 32'hFFFFFFFF, 8'h0, 1'b0, 1'b1, 1'b0, "R3 lsh 31");
    apply(4'b0110, 4'b1010, 32'h80000000, 32'h3F, 8'h0, 1'b0, 1'b1, 1'b0, "R3 rsh logical");
    apply(4'b1000, 4'b0010, 32'hFFFFFFFF, 32'h1, 8'h0, 1'b0, 1'b1, 1'b1, "R10 R6 cmp gt signed");
    apply(4'b1111, 4'b1110, 32'h1, 32'h1, 8'h0, 1'b0, 1'b1, 1'b0, "R10 R5 bit2 ignored");
    apply(4'b0001, 4'b0000, 32'h1, 32'h2, 8'h0, 1'b0, 1'b0, 1'b0, "R7 R8 hold");
    apply(4'b0010, 4'b0000, 32'h7FFFFFFF, 32'h7FFFFFFF, 8'h0, 1'b0, 1'b0, 1'b1, "R8 non-arith ignored");

    // Random stimulus
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] a, b;
      a = $urandom();
      b = ($urandom_range(0, 3) == 0) ? a : $urandom();
      if ($urandom_range(0, 1) == 1) a[W-1] = ~b[W-1];
      apply(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), a, b,
            8'($urandom()), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), "R1 R2 R3 R4 R10 random");
    end

    rst_n = 1'b0;
    #2;
    check("R9 tflag after reset", {31'b0, tflag}, 32'd0);
    check("R9 ovf after reset", {31'b0, ovf}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule